// File: doc/BRIEF.md
# Predicated Floating-Point Maximum Reduction

This unit takes a packed vector of IEEE 754 floating-point lanes and returns the largest one as a single scalar. Only lanes whose predicate bit is set take part. Each inactive lane is replaced by negative infinity, so it can never win. An all-inactive vector therefore produces negative infinity.

The element precision is chosen per request: half, single or double. The lane count is the vector width divided by the element width, so the default 128-bit vector holds 8, 4 or 2 lanes. The lanes are combined in a balanced pairwise tree, with a register after every level. A new vector can be accepted on every cycle, and each result appears a fixed number of cycles later with its own valid strobe.

NaN inputs win every comparison they take part in, and a signalling NaN is quieted on its way out. Zeros are ordered so that +0 beats -0. The scalar sits in the low element-width bits of a wider destination, and every other bit is zero. No flags are produced.

Top module: `fpmax_reduce`

## Requirements
- R1: When a lane's predicate bit is 0, the lane is replaced by negative infinity and cannot affect the result. Predicate bit i governs lane i, which sits at vector bits [i*esize +: esize]. Predicate bits at or above the lane count of the selected precision are ignored.
- R2: With no NaN among the active lanes, the result is the largest active lane. Lanes are reduced pairwise: neighbours first, then pairs of those results, until one value remains.
- R3: If no lane is active, the result is negative infinity of the selected width: 0xFC00 (half), 0xFF800000 (single) or 0xFFF0000000000000 (double).
- R4: If any active lane holds a NaN, the result is a NaN. When several active lanes are NaN, the lowest-indexed one is the one forwarded. A NaN in an inactive lane has no effect.
- R5: A signalling NaN that reaches the output is quieted by setting the top mantissa bit (bit 9, 22 or 51 for half, single or double). Its sign and payload are kept. A quiet NaN passes through unchanged.
- R6: The precision code is 0 for half, 1 for single and 2 for double. Code 3 behaves as double. The result occupies the low 16, 32 or 64 bits of `out_result`, and all higher bits are zero.
- R7: +0 is greater than -0. A -0 that is active still beats inactive lanes.
- R8: Non-NaN values are ordered in sign-magnitude form. When the signs differ, the positive value wins. Among negatives, the smaller magnitude wins. Infinities are ordinary extreme values.
- R9: A result appears exactly log2(VEC_W/16)+1 cycles after `in_valid` (4 by default), with `out_valid` high for exactly one cycle per accepted vector. Back-to-back vectors give back-to-back results.
- R10: Synchronous active-high reset clears `out_valid` and `out_result` to 0 and discards any vectors still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Vector presented this cycle |
| in_fmt | input | 2 | Precision code (0 half, 1 single, 2 or 3 double) |
| in_pred | input | VEC_W/16 | Per-lane predicate, bit i for lane i |
| in_vec | input | VEC_W | Packed source lanes, lane 0 in the low bits |
| out_valid | output | 1 | Result strobe |
| out_result | output | DST_W | Maximum, zero-extended from the element width |

## Verification
The assertions check the following on every cycle:
- The valid strobe advances one stage per level.
- Each tree node forwards one of its two operands.
- A NaN in a node's lower operand is the value that node forwards.
- The output carries no signalling NaN.
- The result is zero above the element width.

Only the bench's scenarios can show the following:
- The numeric ordering: signed zeros, mixed signs, negatives and infinities.
- Predicate substitution, including ignored high predicate bits.
- The all-inactive identity at each precision.
- Exact end-to-end latency and back-to-back throughput.
- Reset flushing vectors that are in flight.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;

    localparam int ELEM_W = 64;

    typedef enum logic [1:0] {
        FMT_H  = 2'd0,
        FMT_S  = 2'd1,
        FMT_D  = 2'd2,
        FMT_DX = 2'd3
    } fmt_e;

    typedef logic [ELEM_W-1:0] elem_t;

    typedef struct packed {
        logic vld;
        fmt_e fmt;
    } tag_t;

    function automatic int unsigned ewidth(fmt_e f);
        case (f)
            FMT_H:   return 16;
            FMT_S:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic sign_of(elem_t x, fmt_e f);
        case (f)
            FMT_H:   return x[15];
            FMT_S:   return x[31];
            default: return x[63];
        endcase
    endfunction

    function automatic elem_t mag_of(elem_t x, fmt_e f);
        case (f)
            FMT_H:   return {49'b0, x[14:0]};
            FMT_S:   return {33'b0, x[30:0]};
            default: return {1'b0, x[62:0]};
        endcase
    endfunction

    function automatic logic is_nan(elem_t x, fmt_e f);
        case (f)
            FMT_H:   return (&x[14:10]) && (|x[9:0]);
            FMT_S:   return (&x[30:23]) && (|x[22:0]);
            default: return (&x[62:52]) && (|x[51:0]);
        endcase
    endfunction

    function automatic logic quiet_bit(elem_t x, fmt_e f);
        case (f)
            FMT_H:   return x[9];
            FMT_S:   return x[22];
            default: return x[51];
        endcase
    endfunction

    function automatic elem_t neg_inf(fmt_e f);
        case (f)
            FMT_H:   return 64'h0000_0000_0000_FC00;
            FMT_S:   return 64'h0000_0000_FF80_0000;
            default: return 64'hFFF0_0000_0000_0000;
        endcase
    endfunction

    function automatic elem_t make_quiet(elem_t x, fmt_e f);
        elem_t r;
        r = x;
        if (is_nan(x, f)) begin
            case (f)
                FMT_H:   r[9]  = 1'b1;
                FMT_S:   r[22] = 1'b1;
                default: r[51] = 1'b1;
            endcase
        end
        return r;
    endfunction

    // a is the lower-indexed operand and wins ties and NaN-vs-NaN.
    function automatic elem_t max2(elem_t a, elem_t b, fmt_e f);
        logic  sa, sb;
        elem_t ma, mb;
        if (is_nan(a, f)) return a;
        if (is_nan(b, f)) return b;
        sa = sign_of(a, f);
        sb = sign_of(b, f);
        ma = mag_of(a, f);
        mb = mag_of(b, f);
        if (sa != sb) return sa ? b : a;
        if (!sa)      return (mb > ma) ? b : a;
        return (mb < ma) ? b : a;
    endfunction

endpackage

// File: rtl/fpmax_lanes.sv
module fpmax_lanes
    import fpmax_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int MAXL  = VEC_W / 16
) (
    input  fmt_e                 fmt,
    input  logic [MAXL-1:0]      pred,
    input  logic [VEC_W-1:0]     vec,
    output elem_t [MAXL-1:0]     lanes
);

    for (genvar i = 0; i < MAXL; i++) begin : g_slot
        localparam bit S_OK = (i < MAXL / 2);
        localparam bit D_OK = (i < MAXL / 4);

        elem_t h_val;
        elem_t s_val;
        elem_t d_val;
        elem_t pick;

        assign h_val = {{(ELEM_W-16){1'b0}}, vec[i*16 +: 16]};

        if (S_OK) begin : g_s
            assign s_val = {{(ELEM_W-32){1'b0}}, vec[i*32 +: 32]};
        end else begin : g_ns
            assign s_val = '0;
        end

        if (D_OK) begin : g_d
            assign d_val = vec[i*64 +: 64];
        end else begin : g_nd
            assign d_val = '0;
        end

        always_comb begin
            case (fmt)
                FMT_H:   pick = pred[i] ? h_val : neg_inf(FMT_H);
                FMT_S:   pick = (S_OK && pred[i]) ? s_val : neg_inf(FMT_S);
                default: pick = (D_OK && pred[i]) ? d_val : neg_inf(FMT_D);
            endcase
        end

        assign lanes[i] = pick;
    end

endmodule

// File: rtl/fpmax_level.sv
module fpmax_level
    import fpmax_pkg::*;
#(
    parameter int NIN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tag_t                 in_tag,
    input  elem_t [NIN-1:0]      din,
    output tag_t                 out_tag,
    output elem_t [NIN/2-1:0]    dout
);

    elem_t [NIN/2-1:0] nxt;

    always_comb begin
        for (int k = 0; k < NIN / 2; k++) begin
            nxt[k] = max2(din[2*k], din[2*k+1], in_tag.fmt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_tag <= '0;
            dout    <= '0;
        end else begin
            out_tag <= in_tag;
            if (in_tag.vld) dout <= nxt;
        end
    end

    AST_VALID_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_tag.vld == $past(in_tag.vld)); // R9

    for (genvar k = 0; k < NIN / 2; k++) begin : g_chk
        AST_NODE_PICKS_OPERAND: assert property (@(posedge clk) disable iff (rst)
            in_tag.vld |=> (dout[k] == $past(din[2*k]) || dout[k] == $past(din[2*k+1]))); // R2
        AST_LOW_NAN_FORWARDED: assert property (@(posedge clk) disable iff (rst)
            in_tag.vld && is_nan(din[2*k], in_tag.fmt) |=> dout[k] == $past(din[2*k])); // R4
    end

endmodule

// File: rtl/fpmax_reduce.sv
module fpmax_reduce
    import fpmax_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int DST_W = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             in_fmt,
    input  logic [VEC_W/16-1:0]    in_pred,
    input  logic [VEC_W-1:0]       in_vec,
    output logic                   out_valid,
    output logic [DST_W-1:0]       out_result
);

    localparam int MAXL = VEC_W / 16;
    localparam int LVLS = $clog2(MAXL);

    fmt_e             fmt_i;
    elem_t [MAXL-1:0] sub_lanes;
    elem_t [MAXL-1:0] s0_data;
    tag_t             s0_tag;

    assign fmt_i = fmt_e'(in_fmt);

    fpmax_lanes #(.VEC_W(VEC_W), .MAXL(MAXL)) u_lanes (
        .fmt   (fmt_i),
        .pred  (in_pred),
        .vec   (in_vec),
        .lanes (sub_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_tag  <= '0;
            s0_data <= '0;
        end else begin
            s0_tag <= '{vld: in_valid, fmt: fmt_i};
            if (in_valid) s0_data <= sub_lanes;
        end
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int NIN = MAXL >> l;

        elem_t [NIN-1:0]   din;
        tag_t              tin;
        elem_t [NIN/2-1:0] dout;
        tag_t              tout;

        if (l == 0) begin : g_first
            assign din = s0_data;
            assign tin = s0_tag;
        end else begin : g_next
            assign din = g_lvl[l-1].dout;
            assign tin = g_lvl[l-1].tout;
        end

        fpmax_level #(.NIN(NIN)) u_level (
            .clk     (clk),
            .rst     (rst),
            .in_tag  (tin),
            .din     (din),
            .out_tag (tout),
            .dout    (dout)
        );
    end

    elem_t fin_val;
    tag_t  fin_tag;
    elem_t fin_q;

    assign fin_val    = g_lvl[LVLS-1].dout[0];
    assign fin_tag    = g_lvl[LVLS-1].tout;
    assign fin_q      = make_quiet(fin_val, fin_tag.fmt);
    assign out_valid  = fin_tag.vld;
    assign out_result = {{(DST_W-ELEM_W){1'b0}}, fin_q};

    AST_RESULT_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result >> ewidth(fin_tag.fmt)) == '0); // R6
    AST_NO_SIGNALLING_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid && is_nan(out_result[ELEM_W-1:0], fin_tag.fmt)
            |-> quiet_bit(out_result[ELEM_W-1:0], fin_tag.fmt)); // R5

endmodule

// File: tb/fpmax_reduce_test.sv
module fpmax_reduce_test;

    typedef struct packed {
        logic [1:0]   fmt;
        logic [7:0]   pred;
        logic [127:0] vec;
        logic [63:0]  exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 8'hFF, 128'h8000_0000_C000_3800_4200_BC00_4000_3C00, 64'h4200},               // R2 half mixed
        '{2'd0, 8'hF7, 128'h8000_0000_C000_3800_4200_BC00_4000_3C00, 64'h4000},               // R1 largest masked
        '{2'd0, 8'hFF, 128'hC000_C000_C000_C000_C000_C200_BC00_C000, 64'hBC00},               // R8 negatives
        '{2'd0, 8'hFF, 128'h8000_8000_8000_8000_8000_8000_0000_8000, 64'h0000},               // R7 +0 wins
        '{2'd0, 8'hFD, 128'h8000_8000_8000_8000_8000_8000_0000_8000, 64'h8000},               // R7 -0 beats inactive
        '{2'd0, 8'h00, 128'h8000_0000_C000_3800_4200_BC00_4000_3C00, 64'hFC00},               // R3 half empty
        '{2'd0, 8'hFF, 128'h3C00_3C00_7E00_3C00_3C00_7C01_3C00_3C00, 64'h7E01},               // R4 R5 lowest NaN quieted
        '{2'd0, 8'hDB, 128'h3C00_3C00_7E00_3C00_3C00_7C01_3C00_3C00, 64'h3C00},               // R4 inactive NaN ignored
        '{2'd0, 8'hFF, 128'h3C00_FC05_3C00_3C00_3C00_3C00_3C00_7C00, 64'hFE05},               // R5 negative sNaN vs +inf
        '{2'd1, 8'hFB, 128'hBF800000_40A00000_C0400000_3F800000, 64'h3F80_0000},              // R6 single, high pred ignored
        '{2'd1, 8'hF0, 128'hBF800000_40A00000_C0400000_3F800000, 64'hFF80_0000},              // R3 single empty
        '{2'd2, 8'h03, 128'h4008000000000000_C000000000000000, 64'h4008_0000_0000_0000},      // R6 double
        '{2'd2, 8'h03, 128'h7FF0000000000001_3FF0000000000000, 64'h7FF8_0000_0000_0001},      // R5 double sNaN
        '{2'd2, 8'hFC, 128'h4008000000000000_C000000000000000, 64'hFFF0_0000_0000_0000},      // R3 double empty
        '{2'd3, 8'h03, 128'h4008000000000000_C000000000000000, 64'h4008_0000_0000_0000},      // R6 code 3 as double
        '{2'd1, 8'h0F, 128'hFFC00123_3F800000_3F800000_7F800000, 64'hFFC0_0123}               // R4 qNaN unchanged
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   in_fmt = 2'd0;
    logic [7:0]   in_pred = '0;
    logic [127:0] in_vec = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fpmax_reduce uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_fmt     (in_fmt),
        .in_pred    (in_pred),
        .in_vec     (in_vec),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] f, input logic [7:0] p, input logic [127:0] v);
        in_fmt   = f;
        in_pred  = p;
        in_vec   = v;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(out_valid == 1'b0, "R10 out_valid in reset", {127'b0, out_valid}, 128'h0);
        chk(out_result == '0, "R10 result in reset", out_result, 128'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive(TBL[n].fmt, TBL[n].pred, TBL[n].vec);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(out_valid == 1'b1, $sformatf("R9 strobe entry %0d", n), {127'b0, out_valid}, 128'h1);
            chk(out_result == {64'h0, TBL[n].exp}, $sformatf("R2 value entry %0d", n), out_result, {64'h0, TBL[n].exp});
            @(negedge clk);
            chk(out_valid == 1'b0, $sformatf("R9 single strobe entry %0d", n), {127'b0, out_valid}, 128'h0);
        end

        // R9 back-to-back throughput
        @(negedge clk);
        drive(TBL[0].fmt, TBL[0].pred, TBL[0].vec);
        @(negedge clk);
        drive(TBL[11].fmt, TBL[11].pred, TBL[11].vec);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R9 not early", {127'b0, out_valid}, 128'h0);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b1, "R9 first of pair", {127'b0, out_valid}, 128'h1);
        chk(out_result == {64'h0, TBL[0].exp}, "R9 first value", out_result, {64'h0, TBL[0].exp});
        @(negedge clk);
        chk(out_valid == 1'b1, "R9 second of pair", {127'b0, out_valid}, 128'h1);
        chk(out_result == {64'h0, TBL[11].exp}, "R9 second value", out_result, {64'h0, TBL[11].exp});
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 pair done", {127'b0, out_valid}, 128'h0);

        // R10 reset flushes an in-flight vector
        @(negedge clk);
        drive(TBL[0].fmt, TBL[0].pred, TBL[0].vec);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_result == '0, "R10 result cleared", out_result, 128'h0);
        rst = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 flushed strobe", {127'b0, out_valid}, 128'h0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule